// File: doc/BRIEF.md
# Tuning-Bias Power Mode and Register Controller

This block is the control core of a serially programmed high-voltage bias generator. It holds the device's 8-bit control registers and runs the power state machine that moves the device between shutdown, startup, active and low power. The serial decoder in front of it turns frames into single-cycle write and read strobes carrying a 5-bit register address. This block applies those strobes, returns read data, and drives the boost converter enable. It also reports when the high-voltage outputs have had their activation time and are ready to use.

The I/O supply-good level acts as the power-on reset. While it is low, everything is held in its off state. When it rises, the block passes through startup with defaults loaded and then enters active. A mode field in the control register requests active, a soft reset or low power. The slave ID used for bus addressing can only be changed by an exact run of three writes to the identification registers. The product ID's top bit follows a board-level ID-select pin, so two identical devices can share one bus.

Top module: `pwr_reg_ctrl`

## Requirements
- R1: While `supply_ok` is low (or `rst_n` is low), `pwr_state` is 0 (shutdown), `boost_en` and `ready` are 0, `rd_data` is 0 and `slave_id` is 7. Writes made during this time are ignored and leave no trace after power-up.
- R2: On the first clock edge with `supply_ok` high after shutdown, `pwr_state` becomes 1 (startup), with every register at its default. One edge later it becomes 2 (active).
- R3: The mode field is bits 7:6 of the control register at address 28. Writing 10 moves an active block to 3 (low power) on the next edge. Writing 00 while in low power returns it to active. Writing 11 changes neither the state nor the stored mode bits, but bits 5:0 are still written.
- R4: Writing mode 01 to address 28 from active or low power is a soft reset. On the next edge every register returns to its default, the slave ID returns to 7 and `pwr_state` is 1. One edge later it is 2.
- R5: `boost_en` is 1 exactly while `pwr_state` is 2.
- R6: `ready` becomes 1 exactly ACT_CYC edges after `pwr_state` first shows 2, where ACT_CYC = CLK_KHZ*ACT_US/1000. It is 0 in every other state. If the block leaves active on the very edge the count would expire, `ready` stays 0.
- R7: Register defaults are: address 28 = 0x38; address 29 = {id_sel, 0x02}, with bit 7 taken from the pin; address 30 = 0x04; address 31 = 0x17; addresses 0, 1 and 2 = 0x00.
- R8: Addresses 29 and 30 ignore writes. Addresses 0, 1 and 2 store the low 7 bits of the write data and read bit 7 as 0. Address 28 reads back what was written, subject to R3. Unmapped addresses read 0.
- R9: `slave_id` is bits 3:0 of address 31. Bits 7:4 of that register read 0001 and are not writable. A lone write to address 31 does not change the slave ID.
- R10: Three consecutive accesses change the slave ID: a write to 29 carrying its current read value, a write to 30 carrying 0x04, then a write to 31. The new ID (write data 3:0) appears on the edge of the third write, and the old ID stays in use until that edge.
- R11: A write to 29 or 30 with any other value, or any other read or write access in between, restarts the slave ID sequence.
- R12: In low power, reads and writes of all registers work as in active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| supply_ok | input | 1 | I/O supply-good level; low means shutdown |
| id_sel | input | 1 | ID-select pin, copied into product ID bit 7 |
| acc_wr | input | 1 | Single-cycle register write strobe |
| acc_rd | input | 1 | Single-cycle register read strobe |
| acc_addr | input | 5 | Register address of the access |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `acc_addr` (combinational) |
| slave_id | output | 4 | Slave ID currently in use |
| pwr_state | output | 2 | 0 shutdown, 1 startup, 2 active, 3 low power |
| boost_en | output | 1 | Boost converter enable |
| ready | output | 1 | Outputs operational after activation time |

## Verification
Two pairs of functions can land on the same clock edge. In the first, the activation counter expires on the same edge that a low-power command is applied. The bench places the mode write exactly ACT_CYC-1 cycles after entering active and requires `ready` to stay low while the state moves to low power. In the second, the supply drops on the same edge as the final write of the slave ID sequence. The bench lowers `supply_ok` in the cycle of the address-31 write and expects shutdown to win: the ID stays at 7, and the register reads 0x17 after the next power-up.

// File: rtl/pwr_reg_pkg.sv
package pwr_reg_pkg;

  typedef enum logic [1:0] {
    PS_OFF  = 2'd0,
    PS_BOOT = 2'd1,
    PS_RUN  = 2'd2,
    PS_DOZE = 2'd3
  } pstate_e;

  localparam int       NUM_DAC  = 3;
  localparam int       AW       = 5;
  localparam int       DW       = 8;
  localparam int       SID_W    = 4;

  localparam logic [AW-1:0] A_CTL = 5'd28;
  localparam logic [AW-1:0] A_PID = 5'd29;
  localparam logic [AW-1:0] A_MID = 5'd30;
  localparam logic [AW-1:0] A_SID = 5'd31;

  localparam logic [DW-1:0]    CTL_DEF = 8'h38;
  localparam logic [6:0]       PID_LOW = 7'h02;
  localparam logic [DW-1:0]    MID_VAL = 8'h04;
  localparam logic [3:0]       SID_HI  = 4'h1;
  localparam logic [SID_W-1:0] SID_DEF = 4'h7;

  localparam logic [1:0] MODE_RUN  = 2'b00;
  localparam logic [1:0] MODE_BOOT = 2'b01;
  localparam logic [1:0] MODE_DOZE = 2'b10;
  localparam logic [1:0] MODE_RSVD = 2'b11;

  // Activation delay in clock cycles, never below one.
  function automatic int act_cycles(input int khz, input int us);
    int c;
    c = (khz * us) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  // Product ID read value: top bit follows the select pin.
  function automatic logic [DW-1:0] pid_value(input logic sel);
    return {sel, PID_LOW};
  endfunction

endpackage

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_reg_pkg::*;
#(
  parameter int CLK_KHZ = 26000,
  parameter int ACT_US  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       ctl_wr,
  input  logic [1:0] ctl_mode,
  output pstate_e    state,
  output logic       enter_run,
  output logic       boost_en,
  output logic       ready
);

  localparam int ACT_CYC = act_cycles(CLK_KHZ, ACT_US);
  localparam int CNT_W   = $clog2(ACT_CYC + 1);

  pstate_e          nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt = state;
    if (!supply_ok) begin
      nxt = PS_OFF;
    end else begin
      unique case (state)
        PS_OFF:  nxt = PS_BOOT;
        PS_BOOT: nxt = PS_RUN;
        PS_RUN: begin
          if (ctl_wr && ctl_mode == MODE_BOOT)      nxt = PS_BOOT;
          else if (ctl_wr && ctl_mode == MODE_DOZE) nxt = PS_DOZE;
        end
        PS_DOZE: begin
          if (ctl_wr && ctl_mode == MODE_BOOT)     nxt = PS_BOOT;
          else if (ctl_wr && ctl_mode == MODE_RUN) nxt = PS_RUN;
        end
        default: nxt = PS_OFF;
      endcase
    end
  end

  assign enter_run = (nxt == PS_RUN) && (state != PS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_OFF;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (!supply_ok)                       cnt <= '0;
      else if (enter_run)                   cnt <= CNT_W'(ACT_CYC);
      else if (state == PS_RUN && cnt != 0) cnt <= cnt - 1'b1;
    end
  end

  assign boost_en = (state == PS_RUN);
  assign ready    = (state == PS_RUN) && (cnt == '0);

  AST_OFF_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> state == PS_OFF); // R1
  AST_BOOT_THEN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_BOOT && supply_ok) |=> state == PS_RUN); // R2
  AST_SOFT_TO_BOOT: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && ctl_wr && ctl_mode == MODE_BOOT && (state == PS_RUN || state == PS_DOZE))
    |=> state == PS_BOOT); // R4
  AST_READY_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(state) == PS_RUN); // R6
  AST_RSVD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && ctl_wr && ctl_mode == MODE_RSVD && state == PS_DOZE) |=> state == PS_DOZE); // R3

endmodule

// File: rtl/reg_bank.sv
module reg_bank
  import pwr_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             awake,
  input  logic             live,
  input  logic             soft_rst,
  input  logic             wr,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    pid_now,
  input  logic [SID_W-1:0] sid,
  output logic [DW-1:0]    ctl_q,
  output logic [DW-1:0]    rd_data
);

  logic [6:0] dac_q [NUM_DAC];
  logic       clear;
  logic       ctl_hit;
  logic [1:0] mode_keep;

  assign clear     = !supply_ok || soft_rst;
  assign ctl_hit   = live && wr && (addr == A_CTL);
  assign mode_keep = (wdata[7:6] == MODE_RSVD) ? ctl_q[7:6] : wdata[7:6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_DEF;
      for (int i = 0; i < NUM_DAC; i++) dac_q[i] <= '0;
    end else if (clear) begin
      ctl_q <= CTL_DEF;
      for (int i = 0; i < NUM_DAC; i++) dac_q[i] <= '0;
    end else begin
      if (ctl_hit) ctl_q <= {mode_keep, wdata[5:0]};
      for (int i = 0; i < NUM_DAC; i++)
        if (live && wr && addr == AW'(i)) dac_q[i] <= wdata[6:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (awake) begin
      case (addr)
        A_CTL:   rd_data = ctl_q;
        A_PID:   rd_data = pid_now;
        A_MID:   rd_data = MID_VAL;
        A_SID:   rd_data = {SID_HI, sid};
        default: begin
          for (int i = 0; i < NUM_DAC; i++)
            if (addr == AW'(i)) rd_data = {1'b0, dac_q[i]};
        end
      endcase
    end
  end

  AST_SOFT_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && supply_ok) |=> ctl_q == CTL_DEF); // R4
  AST_RSVD_MODE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && ctl_hit && !soft_rst && wdata[7:6] == MODE_RSVD) |=> $stable(ctl_q[7:6])); // R3
  AST_OFF_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |-> rd_data == '0); // R1

endmodule

// File: rtl/sid_seq.sv
module sid_seq
  import pwr_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             supply_ok,
  input  logic             live,
  input  logic             soft_rst,
  input  logic             wr,
  input  logic             rd,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    pid_now,
  output logic [SID_W-1:0] sid,
  output logic             commit
);

  logic [1:0] step;
  logic       hit_pid, hit_mid, hit_sid, access;

  assign access  = live && (wr || rd);
  assign hit_pid = wr && (addr == A_PID) && (wdata == pid_now);
  assign hit_mid = wr && (addr == A_MID) && (wdata == MID_VAL);
  assign hit_sid = wr && (addr == A_SID);
  assign commit  = access && (step == 2'd2) && hit_sid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      sid  <= SID_DEF;
    end else if (!supply_ok || soft_rst) begin
      step <= '0;
      sid  <= SID_DEF;
    end else if (access) begin
      if (hit_pid)                     step <= 2'd1;
      else if (step == 2'd1 && hit_mid) step <= 2'd2;
      else                             step <= 2'd0;
      if (commit) sid <= wdata[SID_W-1:0];
    end
  end

  AST_SID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !soft_rst && !commit) |=> $stable(sid)); // R10
  AST_SID_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> sid == SID_DEF); // R1
  AST_STEP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && !soft_rst && access && !hit_pid && !hit_mid) |=> step == 2'd0); // R11

endmodule

// File: rtl/pwr_reg_ctrl.sv
module pwr_reg_ctrl
  import pwr_reg_pkg::*;
#(
  parameter int CLK_KHZ = 26000,
  parameter int ACT_US  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       id_sel,
  input  logic       acc_wr,
  input  logic       acc_rd,
  input  logic [4:0] acc_addr,
  input  logic [7:0] acc_wdata,
  output logic [7:0] rd_data,
  output logic [3:0] slave_id,
  output logic [1:0] pwr_state,
  output logic       boost_en,
  output logic       ready
);

  pstate_e          state;
  logic             live, awake, ctl_wr, soft_rst, enter_run, commit;
  logic [1:0]       ctl_mode;
  logic [DW-1:0]    pid_now, ctl_q;
  logic [SID_W-1:0] sid;

  assign live     = (state == PS_RUN) || (state == PS_DOZE);
  assign awake    = (state != PS_OFF);
  assign ctl_wr   = live && acc_wr && (acc_addr == A_CTL);
  assign ctl_mode = acc_wdata[7:6];
  assign soft_rst = ctl_wr && (ctl_mode == MODE_BOOT);
  assign pid_now  = pid_value(id_sel);

  pwr_fsm #(.CLK_KHZ(CLK_KHZ), .ACT_US(ACT_US)) u_fsm (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
    .state(state), .enter_run(enter_run), .boost_en(boost_en), .ready(ready)
  );

  reg_bank u_regs (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .awake(awake), .live(live),
    .soft_rst(soft_rst), .wr(acc_wr), .addr(acc_addr), .wdata(acc_wdata),
    .pid_now(pid_now), .sid(sid), .ctl_q(ctl_q), .rd_data(rd_data)
  );

  sid_seq u_sid (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .live(live), .soft_rst(soft_rst),
    .wr(acc_wr), .rd(acc_rd), .addr(acc_addr), .wdata(acc_wdata),
    .pid_now(pid_now), .sid(sid), .commit(commit)
  );

  assign slave_id  = sid;
  assign pwr_state = state;

  AST_ENTER_GIVES_BOOST: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_run && supply_ok) |=> boost_en && !ready); // R5
  AST_DOZE_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_ok && ctl_wr && ctl_mode == MODE_DOZE) |=> !ready && !boost_en); // R6
  AST_MODE_STORED_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_DOZE) |-> ctl_q[7:6] == MODE_DOZE); // R3
  AST_COMMIT_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> live); // R10

endmodule

// File: tb/pwr_reg_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_reg_ctrl_bench;

  localparam int RUN_WAIT = 20; // 100 us activation counted at 200 kHz -> 20 cycles

  logic       clk = 1'b0;
  logic       rst_n, supply_ok, id_sel, acc_wr, acc_rd;
  logic [4:0] acc_addr;
  logic [7:0] acc_wdata;
  logic [7:0] rd_data;
  logic [3:0] slave_id;
  logic [1:0] pwr_state;
  logic       boost_en, ready;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  pwr_reg_ctrl #(.CLK_KHZ(200), .ACT_US(100)) u_pwr_reg_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .id_sel(id_sel),
    .acc_wr(acc_wr), .acc_rd(acc_rd), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rd_data(rd_data), .slave_id(slave_id), .pwr_state(pwr_state),
    .boost_en(boost_en), .ready(ready)
  );

  // {write?, address, write data, expected read}
  typedef struct packed {
    logic       wr;
    logic [4:0] addr;
    logic [7:0] data;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'd28, 8'h00, 8'h38},  // R7 control default
    '{1'b0, 5'd29, 8'h00, 8'h82},  // R7 product ID with id_sel=1
    '{1'b0, 5'd30, 8'h00, 8'h04},  // R7
    '{1'b0, 5'd31, 8'h00, 8'h17},  // R7
    '{1'b0, 5'd0,  8'h00, 8'h00},  // R7
    '{1'b1, 5'd0,  8'hFF, 8'h7F},  // R8 bit 7 reads 0
    '{1'b1, 5'd1,  8'h55, 8'h55},  // R8
    '{1'b1, 5'd2,  8'h80, 8'h00},  // R8
    '{1'b1, 5'd29, 8'hFF, 8'h82},  // R8 read-only
    '{1'b1, 5'd30, 8'h00, 8'h04},  // R8 read-only
    '{1'b1, 5'd31, 8'h1A, 8'h17},  // R9 lone write does not move the ID
    '{1'b1, 5'd28, 8'h07, 8'h07},  // R8 control read/write, mode 00
    '{1'b1, 5'd28, 8'h38, 8'h38},  // R8
    '{1'b0, 5'd5,  8'h00, 8'h00}   // R8 unmapped
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_wr = 1'b0;
  endtask

  task automatic rd_strobe(input logic [4:0] a);
    @(negedge clk);
    acc_rd = 1'b1; acc_addr = a;
    @(negedge clk);
    acc_rd = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, input logic [7:0] exp, input string tag);
    acc_addr = a;
    #0.2;
    chk(tag, rd_data, exp);
  endtask

  // Called at the negedge where pwr_state first reads active.
  task automatic wait_ready(input string tag);
    int early = 0;
    repeat (RUN_WAIT - 1) begin
      @(negedge clk);
      if (ready) early++;
    end
    chk({tag, " ready early"}, early, 0);
    @(negedge clk);
    chk({tag, " ready on time"}, ready, 1'b1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; id_sel = 1'b1;
    acc_wr = 1'b0; acc_rd = 1'b0; acc_addr = '0; acc_wdata = '0;
    #12;
    @(negedge clk);
    // R1 reset / shutdown state
    chk("R1 state", pwr_state, 2'd0);
    chk("R1 boost", boost_en, 1'b0);
    chk("R1 ready", ready, 1'b0);
    chk("R1 slave id", slave_id, 4'h7);
    peek(5'd28, 8'h00, "R1 read in shutdown");
    rst_n = 1'b1;
    wr(5'd0, 8'h33);  // R1 ignored while supply is low
    chk("R1 still off", pwr_state, 2'd0);

    // R2 power-up, R5 boost, R6 activation
    supply_ok = 1'b1;
    @(negedge clk);
    chk("R2 startup", pwr_state, 2'd1);
    chk("R5 boost off in startup", boost_en, 1'b0);
    @(negedge clk);
    chk("R2 active", pwr_state, 2'd2);
    chk("R5 boost in active", boost_en, 1'b1);
    wait_ready("R6 power-up");
    peek(5'd0, 8'h00, "R1 shutdown write left no trace");

    // Table walk: R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else @(negedge clk);
      peek(VEC[i].addr, VEC[i].exp, $sformatf("R7/R8/R9 table step %0d", i));
    end

    // R11 wrong product ID value
    wr(5'd29, 8'h02); wr(5'd30, 8'h04); wr(5'd31, 8'h13);
    chk("R11 wrong pid value", slave_id, 4'h7);
    // R11 wrong manufacturer value
    wr(5'd29, 8'h82); wr(5'd30, 8'h05); wr(5'd31, 8'h13);
    chk("R11 wrong mid value", slave_id, 4'h7);
    // R11 intervening read
    wr(5'd29, 8'h82); wr(5'd30, 8'h04); rd_strobe(5'd28); wr(5'd31, 8'h13);
    chk("R11 intervening read", slave_id, 4'h7);

    // R10 full sequence, old ID until the third write's edge
    wr(5'd29, 8'h82); wr(5'd30, 8'h04);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = 5'd31; acc_wdata = 8'h1A;
    #0.2;
    chk("R10 old id before edge", slave_id, 4'h7);
    @(negedge clk);
    acc_wr = 1'b0;
    chk("R10 new id", slave_id, 4'hA);
    peek(5'd31, 8'h1A, "R10 register 31 readback");

    // R3 low power, R5, R12
    wr(5'd28, 8'h80);
    chk("R3 low power", pwr_state, 2'd3);
    chk("R5 boost off in low power", boost_en, 1'b0);
    chk("R6 ready off in low power", ready, 1'b0);
    peek(5'd1, 8'h55, "R12 read in low power");
    wr(5'd0, 8'h11);
    peek(5'd0, 8'h11, "R12 write in low power");
    wr(5'd28, 8'hC5);
    chk("R3 reserved mode keeps state", pwr_state, 2'd3);
    peek(5'd28, 8'h85, "R3 reserved mode keeps bits");
    wr(5'd28, 8'h00);
    chk("R3 back to active", pwr_state, 2'd2);
    wait_ready("R6 wake");

    // R4 soft reset
    wr(5'd28, 8'h40);
    chk("R4 startup", pwr_state, 2'd1);
    peek(5'd28, 8'h38, "R4 control default");
    peek(5'd0, 8'h00, "R4 dac default");
    peek(5'd1, 8'h00, "R4 dac default");
    chk("R4 slave id default", slave_id, 4'h7);
    @(negedge clk);
    chk("R4 active", pwr_state, 2'd2);

    // R6 same edge: count expiry with low-power command
    repeat (RUN_WAIT - 1) @(negedge clk);
    chk("R6 not ready one before", ready, 1'b0);
    acc_wr = 1'b1; acc_addr = 5'd28; acc_wdata = 8'h80;
    @(negedge clk);
    acc_wr = 1'b0;
    chk("R6 collision state", pwr_state, 2'd3);
    chk("R6 collision ready", ready, 1'b0);
    wr(5'd28, 8'h00);
    chk("R3 active again", pwr_state, 2'd2);

    // R1 supply loss on the commit edge
    wr(5'd29, 8'h82); wr(5'd30, 8'h04);
    @(negedge clk);
    acc_wr = 1'b1; acc_addr = 5'd31; acc_wdata = 8'h19; supply_ok = 1'b0;
    @(negedge clk);
    acc_wr = 1'b0;
    chk("R1 loss wins state", pwr_state, 2'd0);
    chk("R1 loss wins id", slave_id, 4'h7);
    peek(5'd31, 8'h00, "R1 read after loss");
    supply_ok = 1'b1;
    @(negedge clk);
    chk("R2 restart startup", pwr_state, 2'd1);
    @(negedge clk);
    chk("R2 restart active", pwr_state, 2'd2);
    peek(5'd31, 8'h17, "R7 id register after restart");

    // R7 id_sel low
    id_sel = 1'b0;
    peek(5'd29, 8'h02, "R7 product id with id_sel=0");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule